// File: doc/BRIEF.md
# eMMC Host Initialization Sequencer

This block is the host-side controller that brings a managed-flash device from power-on to a configured high-speed transfer state. It runs a fixed ladder of commands:
- a power-up wait;
- a go-idle reset;
- a polled operating-conditions handshake;
- reading the identification register and assigning the relative address;
- reading the card-specific register and selecting the device;
- re-reading the identification register to confirm it;
- requesting the extended register and switching the speed mode;
- a settle delay, then polling status until the switch is complete.

Each command goes to a command serializer on a valid/ready request channel. Each reply comes back on a valid/ready response channel. The sequencer never touches the CMD or DAT lines itself, and it does not parse extended-register data.

Errors follow one recovery path. A bad status word, a timeout or a CRC fault causes a stop-transmission command, after which the failing command is issued again. Both the retries and the busy polling are bounded, and exceeding either limit ends the sequence with a sticky failure flag. A `start` pulse given while the block is idle clears both outcome flags and runs the whole ladder again, beginning with the power-up wait. All millisecond waits are derived from the `CLK_HZ` parameter.

Top module: `emmc_init_seq`

## Requirements
- R1: While reset is asserted, `cmd_valid`, `init_done` and `init_failed` are low. After reset is released, and after any `start`, no command is offered for at least `POWERUP_MS*CLK_HZ/1000` cycles.
- R2: The first command is index 0 with argument 0. Its short response must show device state 0 in bits [12:9] and no error bit; anything else is treated as an error.
- R3: Index 1 is issued with argument 0x40FF8000. It is repeated while response bit 31 is 0 and the ladder advances once bit 31 is 1. After `MAX_POLLS` busy replies on one step, the sequence fails.
- R4: After the ready reply, the sequence is: index 2 (argument 0), index 3, index 9, index 7. Every addressed command (3, 7, 8, 9, 12, 13) carries `RCA` in argument bits [31:16] and zero in bits [15:0].
- R5: Index 2 is issued again after index 7. Its 128-bit response is compared with the one stored from the first read. On a mismatch the sequence fails at once and issues no further command.
- R6: Index 8 is then followed by index 6. The index-6 argument is built as follows:
  - bits [25:24] = 3 (write byte);
  - bits [23:16] = 185;
  - bits [15:8] = `SPEED_SEL`;
  - bits [2:0] = `CMD_SET`;
  - all other bits = 0.
- R7: After the index-6 response, at least `SETTLE_MS*CLK_HZ/1000` cycles pass before index 13 is offered. Index 13 repeats until the status shows state 4 in bits [12:9] and bit 8 set. `init_done` then rises.
- R8: Any of the following is an error: a timeout, a CRC fault, or — in a short response other than the index-1 reply — any of bits [31:16] or bit 7 set. On an error the sequencer issues index 12 and then reissues the same command. The response to index 12 is not checked.
- R9: Each step allows at most `MAX_RETRY` recoveries. The next error on that step sets `init_failed` and returns the block to idle. `init_done` and `init_failed` are never high together, and no command is offered while either is high.
- R10: Command back-pressure: a command is held unchanged on `cmd_index`/`cmd_arg` while `cmd_valid` is high and `cmd_ready` is low. Response back-pressure: `rsp_ready` is high only while a response is awaited. At most one command is outstanding at any time.
- R11: A `start` pulse while idle clears both flags on the next cycle and reruns the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Rerun request, honoured only when idle |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Serializer accepts the command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_rsp_kind | output | 2 | Expected response: 0 none, 1 short, 2 long (128-bit), 3 short with busy |
| rsp_valid | input | 1 | Response present |
| rsp_ready | output | 1 | Sequencer awaiting a response |
| rsp_word | input | 128 | Response; short replies in [31:0] |
| rsp_timeout | input | 1 | No reply arrived (qualified by `rsp_valid`) |
| rsp_crc_err | input | 1 | Reply failed its CRC (qualified by `rsp_valid`) |
| init_done | output | 1 | Sticky: sequence completed |
| init_failed | output | 1 | Sticky: sequence aborted |

## Verification
Result timing:
- A new command is offered two cycles after the response that permits it is accepted: one cycle for the accept, one for the phase change.
- The power-up wait ends `POWERUP_MS*CLK_HZ/1000`+1 cycles after its trigger.
- Index 13 follows the index-6 reply by the settle count plus two cycles.

Because `cmd_ready` stalls and response latency are randomized, the bench time-stamps every accepted command and every delivered response. It checks these waits as lower bounds between stamps, and holds the power-up window to a tolerance of three cycles. Sequence checks compare the full recorded command log against a log that the bench builds from its own fault knobs. Outcome flags are sampled on the falling edge after they rise.

// File: rtl/emmc_init_pkg.sv
package emmc_init_pkg;

  typedef enum logic [1:0] {
    RSP_NONE       = 2'd0,
    RSP_SHORT      = 2'd1,
    RSP_LONG       = 2'd2,
    RSP_SHORT_BUSY = 2'd3
  } rsp_kind_e;

  typedef enum logic [3:0] {
    ST_GO_IDLE,
    ST_OPCOND,
    ST_CID,
    ST_RCA,
    ST_CSD,
    ST_SELECT,
    ST_CID_CHK,
    ST_EXTCSD,
    ST_SWITCH,
    ST_STATUS,
    ST_STOP
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_WAIT,
    PH_ISSUE,
    PH_RESP
  } phase_e;

  localparam logic [31:0] OCR_ARG     = 32'h40FF_8000;
  localparam logic [3:0]  DEV_ST_IDLE = 4'd0;
  localparam logic [3:0]  DEV_ST_TRAN = 4'd4;
  localparam logic [7:0]  TIMING_BYTE = 8'd185;

  function automatic logic [31:0] switch_arg(input logic [7:0] idx,
                                             input logic [7:0] val,
                                             input logic [2:0] cset);
    return {6'd0, 2'b11, idx, val, 5'd0, cset};
  endfunction

  function automatic logic r1_has_error(input logic [31:0] w);
    return (|w[31:16]) | w[7];
  endfunction

endpackage

// File: rtl/emmc_init_timer.sv
module emmc_init_timer #(
  parameter int TW        = 16,
  parameter int RESET_VAL = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= TW'(RESET_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R1
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  // R1
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/emmc_init_cmd_rom.sv
module emmc_init_cmd_rom
  import emmc_init_pkg::*;
#(
  parameter logic [15:0] RCA       = 16'h0001,
  parameter logic [7:0]  SPEED_SEL = 8'h02,
  parameter logic [2:0]  CMD_SET   = 3'd0
) (
  input  step_e       step,
  output logic [5:0]  idx,
  output logic [31:0] arg,
  output logic [1:0]  kind
);
  localparam logic [31:0] ADDR_ARG = {RCA, 16'h0000};

  always_comb begin
    idx  = 6'd0;
    arg  = 32'h0;
    kind = RSP_SHORT;
    case (step)
      ST_GO_IDLE: begin idx = 6'd0;  arg = 32'h0;    kind = RSP_SHORT;      end
      ST_OPCOND:  begin idx = 6'd1;  arg = OCR_ARG;  kind = RSP_SHORT;      end
      ST_CID:     begin idx = 6'd2;  arg = 32'h0;    kind = RSP_LONG;       end
      ST_RCA:     begin idx = 6'd3;  arg = ADDR_ARG; kind = RSP_SHORT;      end
      ST_CSD:     begin idx = 6'd9;  arg = ADDR_ARG; kind = RSP_LONG;       end
      ST_SELECT:  begin idx = 6'd7;  arg = ADDR_ARG; kind = RSP_SHORT_BUSY; end
      ST_CID_CHK: begin idx = 6'd2;  arg = 32'h0;    kind = RSP_LONG;       end
      ST_EXTCSD:  begin idx = 6'd8;  arg = ADDR_ARG; kind = RSP_SHORT;      end
      ST_SWITCH:  begin idx = 6'd6;  arg = switch_arg(TIMING_BYTE, SPEED_SEL, CMD_SET);
                        kind = RSP_SHORT_BUSY; end
      ST_STATUS:  begin idx = 6'd13; arg = ADDR_ARG; kind = RSP_SHORT;      end
      ST_STOP:    begin idx = 6'd12; arg = ADDR_ARG; kind = RSP_SHORT_BUSY; end
      default:    begin idx = 6'd0;  arg = 32'h0;    kind = RSP_NONE;       end
    endcase
  end
endmodule

// File: rtl/emmc_init_rsp_eval.sv
module emmc_init_rsp_eval
  import emmc_init_pkg::*;
(
  input  step_e          step,
  input  logic [127:0]   rsp_word,
  input  logic           rsp_timeout,
  input  logic           rsp_crc_err,
  input  logic [127:0]   cid_ref,
  output logic           is_err,
  output logic           not_ready,
  output logic           cid_bad
);
  logic [31:0] w;
  assign w = rsp_word[31:0];

  always_comb begin
    is_err    = rsp_timeout | rsp_crc_err;
    not_ready = 1'b0;
    cid_bad   = 1'b0;
    case (step)
      ST_GO_IDLE: is_err = is_err | r1_has_error(w) | (w[12:9] != DEV_ST_IDLE);
      ST_OPCOND:  not_ready = !is_err && !w[31];
      ST_CID, ST_CSD: ;
      ST_CID_CHK: cid_bad = !is_err && (rsp_word != cid_ref);
      ST_STATUS: begin
        is_err    = is_err | r1_has_error(w);
        not_ready = !is_err && !((w[12:9] == DEV_ST_TRAN) && w[8]);
      end
      default:    is_err = is_err | r1_has_error(w);
    endcase
  end
endmodule

// File: rtl/emmc_init_seq.sv
module emmc_init_seq
  import emmc_init_pkg::*;
#(
  parameter int          CLK_HZ     = 50_000_000,
  parameter int          POWERUP_MS = 5,
  parameter int          SETTLE_MS  = 1,
  parameter int          MAX_POLLS  = 1000,
  parameter int          MAX_RETRY  = 3,
  parameter logic [15:0] RCA        = 16'h0001,
  parameter logic [7:0]  SPEED_SEL  = 8'h02,
  parameter logic [2:0]  CMD_SET    = 3'd0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output logic         cmd_valid,
  input  logic         cmd_ready,
  output logic [5:0]   cmd_index,
  output logic [31:0]  cmd_arg,
  output logic [1:0]   cmd_rsp_kind,
  input  logic         rsp_valid,
  output logic         rsp_ready,
  input  logic [127:0] rsp_word,
  input  logic         rsp_timeout,
  input  logic         rsp_crc_err,
  output logic         init_done,
  output logic         init_failed
);
  localparam int TICKS_MS  = CLK_HZ / 1000;
  localparam int PWR_TICKS = POWERUP_MS * TICKS_MS;
  localparam int SET_TICKS = SETTLE_MS * TICKS_MS;
  localparam int MAXT      = (PWR_TICKS > SET_TICKS) ? PWR_TICKS : SET_TICKS;
  localparam int TW        = $clog2(MAXT + 2);
  localparam int PW        = $clog2(MAX_POLLS + 2);
  localparam int RW        = $clog2(MAX_RETRY + 2);

  phase_e         phase;
  step_e          step;
  step_e          rom_step;
  logic           in_stop;
  logic [PW-1:0]  poll_cnt;
  logic [RW-1:0]  retry_cnt;
  logic [127:0]   cid_q;
  logic           done_q, fail_q;

  logic           ev_err, ev_not_ready, ev_cid_bad;
  logic           rsp_fire, step_ok;
  logic           tmr_load, tmr_expired;
  logic [TW-1:0]  tmr_val;

  assign rom_step = in_stop ? ST_STOP : step;

  emmc_init_cmd_rom #(
    .RCA(RCA), .SPEED_SEL(SPEED_SEL), .CMD_SET(CMD_SET)
  ) u_rom (
    .step(rom_step), .idx(cmd_index), .arg(cmd_arg), .kind(cmd_rsp_kind)
  );

  emmc_init_rsp_eval u_eval (
    .step(step), .rsp_word(rsp_word), .rsp_timeout(rsp_timeout),
    .rsp_crc_err(rsp_crc_err), .cid_ref(cid_q),
    .is_err(ev_err), .not_ready(ev_not_ready), .cid_bad(ev_cid_bad)
  );

  emmc_init_timer #(
    .TW(TW), .RESET_VAL(PWR_TICKS)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  assign rsp_fire = (phase == PH_RESP) && rsp_valid;
  assign step_ok  = rsp_fire && !in_stop && !ev_err && !ev_not_ready && !ev_cid_bad;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(SET_TICKS);
    if (phase == PH_IDLE && start) begin
      tmr_load = 1'b1;
      tmr_val  = TW'(PWR_TICKS);
    end else if (step_ok && step == ST_SWITCH) begin
      tmr_load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_WAIT;
      step      <= ST_GO_IDLE;
      in_stop   <= 1'b0;
      poll_cnt  <= '0;
      retry_cnt <= '0;
      cid_q     <= '0;
      done_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase     <= PH_WAIT;
            step      <= ST_GO_IDLE;
            in_stop   <= 1'b0;
            poll_cnt  <= '0;
            retry_cnt <= '0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
          end
        end
        PH_WAIT: begin
          if (tmr_expired) phase <= PH_ISSUE;
        end
        PH_ISSUE: begin
          if (cmd_ready) phase <= PH_RESP;
        end
        PH_RESP: begin
          if (rsp_valid) begin
            if (in_stop) begin
              in_stop <= 1'b0;
              phase   <= PH_ISSUE;
            end else if (ev_cid_bad) begin
              fail_q <= 1'b1;
              phase  <= PH_IDLE;
            end else if (ev_err) begin
              if (retry_cnt == RW'(MAX_RETRY)) begin
                fail_q <= 1'b1;
                phase  <= PH_IDLE;
              end else begin
                retry_cnt <= retry_cnt + 1'b1;
                in_stop   <= 1'b1;
                phase     <= PH_ISSUE;
              end
            end else if (ev_not_ready) begin
              if (poll_cnt == PW'(MAX_POLLS - 1)) begin
                fail_q <= 1'b1;
                phase  <= PH_IDLE;
              end else begin
                poll_cnt <= poll_cnt + 1'b1;
                phase    <= PH_ISSUE;
              end
            end else begin
              poll_cnt  <= '0;
              retry_cnt <= '0;
              if (step == ST_CID) cid_q <= rsp_word;
              case (step)
                ST_SWITCH: begin step <= ST_STATUS; phase <= PH_WAIT; end
                ST_STATUS: begin done_q <= 1'b1; phase <= PH_IDLE; end
                default:   begin step <= step_e'(step + 4'd1); phase <= PH_ISSUE; end
              endcase
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign cmd_valid   = (phase == PH_ISSUE);
  assign rsp_ready   = (phase == PH_RESP);
  assign init_done   = done_q;
  assign init_failed = fail_q;

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_index) && $stable(cmd_arg)));

  // R10
  rsp_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> !rsp_ready);

  // R4
  rca_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_index == 6'd3 || cmd_index == 6'd7 || cmd_index == 6'd8 ||
                   cmd_index == 6'd9 || cmd_index == 6'd12 || cmd_index == 6'd13))
      |-> (cmd_arg == {RCA, 16'h0000}));

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !init_failed);

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done || init_failed) |-> !cmd_valid);

  // R5
  cid_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fire && !in_stop && ev_cid_bad) |=> (init_failed && !cmd_valid));
endmodule

// File: tb/emmc_init_seq_test.sv
module emmc_init_seq_test;
  localparam int TPM       = 10;
  localparam int PWR       = 5 * TPM;
  localparam int MAX_POLLS = 6;
  localparam int MAX_RETRY = 2;
  localparam logic [31:0] RCA_ARG = 32'h0005_0000;
  localparam logic [31:0] OCR     = 32'h40FF_8000;
  localparam logic [31:0] SW_ARG  = 32'h03B9_0200;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, cmd_ready = 1'b0, rsp_valid = 1'b0;
  logic rsp_timeout = 1'b0, rsp_crc_err = 1'b0;
  logic [127:0] rsp_word = '0;
  logic cmd_valid, rsp_ready, init_done, init_failed;
  logic [5:0] cmd_index;
  logic [31:0] cmd_arg;
  logic [1:0] cmd_rsp_kind;

  emmc_init_seq #(
    .CLK_HZ(TPM * 1000), .POWERUP_MS(5), .SETTLE_MS(1), .MAX_POLLS(MAX_POLLS),
    .MAX_RETRY(MAX_RETRY), .RCA(16'h0005), .SPEED_SEL(8'h02), .CMD_SET(3'd0)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .cmd_rsp_kind(cmd_rsp_kind), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_word(rsp_word), .rsp_timeout(rsp_timeout), .rsp_crc_err(rsp_crc_err),
    .init_done(init_done), .init_failed(init_failed)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // knobs, written only by the main process
  int k_busy, k_nrdy, k_ecmd, k_en, k_emode, k_lat, run_id = 0;
  bit k_cidbad, k_rr;
  logic [127:0] cid_val = 128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978;

  // log, written only by the device model
  int log_n = 0;
  int log_idx [0:255];
  logic [31:0] log_arg [0:255];
  int log_t [0:255];
  int rsp_t [0:255];

  // expected log, built by the main process
  int n_exp;
  bit exp_fail;
  int x_err;
  int exp_idx [0:255];
  logic [31:0] exp_arg [0:255];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // device model
  initial begin
    int seen = 0, busy_left = 0, nrdy_left = 0, err_left = 0, cid_reads = 0;
    int idx;
    logic [127:0] w;
    logic to, crc;
    forever begin
      @(negedge clk);
      if (run_id != seen) begin
        seen = run_id; busy_left = k_busy; nrdy_left = k_nrdy;
        err_left = k_en; cid_reads = 0; log_n = 0;
      end
      if (!rst_n || !cmd_valid) continue;
      if (k_rr && ($urandom % 3 == 0)) begin cmd_ready = 1'b0; continue; end
      cmd_ready = 1'b1;
      idx = int'(cmd_index);
      log_idx[log_n] = idx; log_arg[log_n] = cmd_arg; log_t[log_n] = cyc;
      @(negedge clk);
      cmd_ready = 1'b0;
      repeat (k_lat) @(negedge clk);
      w = '0; to = 1'b0; crc = 1'b0;
      if (err_left > 0 && idx == k_ecmd) begin
        err_left--;
        if (idx == 1 || idx == 2 || idx == 9) to = 1'b1;
        else case (k_emode)
          0: w[31:0] = 32'h0008_0900;
          1: to = 1'b1;
          2: crc = 1'b1;
          3: w[31:0] = 32'h0000_0980;
          default: w[31:0] = 32'h0000_0200;
        endcase
      end else begin
        case (idx)
          0: w = '0;
          1: if (busy_left > 0) begin busy_left--; w[31:0] = 32'h00FF_8080; end
             else w[31:0] = 32'hC0FF_8080;
          2: begin cid_reads++; w = (cid_reads > 1 && k_cidbad) ? (cid_val ^ 128'h100) : cid_val; end
          3: w[31:0] = 32'h0000_0400;
          9: w = 128'hA5A5_0000_1111_2222_3333_4444_5555_6666;
          7: w[31:0] = 32'h0000_0600;
          13: if (nrdy_left > 0) begin nrdy_left--; w[31:0] = 32'h0000_0E00; end
              else w[31:0] = 32'h0000_0900;
          default: w[31:0] = 32'h0000_0900;
        endcase
      end
      rsp_word = w; rsp_timeout = to; rsp_crc_err = crc; rsp_valid = 1'b1;
      rsp_t[log_n] = cyc;
      log_n++;
      @(negedge clk);
      rsp_valid = 1'b0; rsp_timeout = 1'b0; rsp_crc_err = 1'b0;
    end
  end

  // handshake monitor for R10
  int hs_viol = 0;
  initial begin
    bit pv = 0, pr = 0;
    logic [5:0] pi;
    logic [31:0] pa;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (cmd_valid && rsp_ready) hs_viol++;
        if (pv && !pr && (!cmd_valid || cmd_index != pi || cmd_arg != pa)) hs_viol++;
        pv = cmd_valid; pr = cmd_ready; pi = cmd_index; pa = cmd_arg;
      end else pv = 0;
    end
  end

  task automatic add(input int i, input logic [31:0] a);
    exp_idx[n_exp] = i; exp_arg[n_exp] = a; n_exp++;
  endtask

  task automatic add_step(input int i, input logic [31:0] a, input int polls);
    int e = 0;
    if (exp_fail) return;
    while (x_err > 0 && i == k_ecmd) begin
      add(i, a); x_err--;
      if (e == MAX_RETRY) begin exp_fail = 1; return; end
      e++; add(12, RCA_ARG);
    end
    if (polls >= MAX_POLLS) begin
      repeat (MAX_POLLS) add(i, a);
      exp_fail = 1; return;
    end
    repeat (polls) add(i, a);
    add(i, a);
  endtask

  task automatic build_expected();
    n_exp = 0; exp_fail = 0; x_err = k_en;
    add_step(0, 32'h0, 0);
    add_step(1, OCR, k_busy);
    add_step(2, 32'h0, 0);
    add_step(3, RCA_ARG, 0);
    add_step(9, RCA_ARG, 0);
    add_step(7, RCA_ARG, 0);
    add_step(2, 32'h0, 0);
    if (!exp_fail && k_cidbad) exp_fail = 1;
    add_step(8, RCA_ARG, 0);
    add_step(6, SW_ARG, 0);
    add_step(13, RCA_ARG, k_nrdy);
  endtask

  task automatic run(input string req, input int busy, input int nrdy, input int ecmd,
                     input int en, input int emode, input bit cidbad, input int lat,
                     input bit rr, input bit use_start);
    int t = 0, w = 0, mism = 0, first = -1;
    k_busy = busy; k_nrdy = nrdy; k_ecmd = ecmd; k_en = en; k_emode = emode;
    k_cidbad = cidbad; k_lat = lat; k_rr = rr; run_id++;
    build_expected();
    @(negedge clk);
    if (use_start) begin
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(!init_done && !init_failed, "R11", "flags cleared after start",
          {init_done, init_failed}, 0);
    end else rst_n = 1'b1;
    while (!cmd_valid && t < 20000) begin @(negedge clk); t++; end
    chk(t >= PWR && t <= PWR + 3, "R1", "cycles before first command", t, PWR);
    while (!(init_done || init_failed) && w < 20000) begin @(negedge clk); w++; end
    chk(w < 20000, req, "watchdog expired", w, 0);
    repeat (3) @(negedge clk);
    chk(init_done == !exp_fail && init_failed == exp_fail, req, "outcome done/failed",
        {init_done, init_failed}, {!exp_fail, exp_fail});
    for (int i = 0; i < n_exp && i < log_n; i++)
      if (log_idx[i] != exp_idx[i] || log_arg[i] != exp_arg[i]) begin
        mism++; if (first < 0) first = i;
      end
    chk(log_n == n_exp, req, "command count", log_n, n_exp);
    chk(mism == 0, req, "command log mismatches (first index in actual)",
        mism, (first < 0) ? 0 : first);
  endtask

  initial begin
    int ecmds [8] = '{0, 3, 9, 7, 8, 6, 13, 2};
    int j6;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!cmd_valid && !init_done && !init_failed, "R1", "outputs during reset",
        {cmd_valid, init_done, init_failed}, 0);

    // nominal: R2 R3 R4 R5 R6 R7
    run("R3", 2, 1, -1, 0, 0, 0, 1, 0, 0);
    j6 = -1;
    for (int i = 0; i < log_n; i++) if (log_idx[i] == 6) j6 = i;
    chk(j6 >= 0 && log_arg[j6] == SW_ARG, "R6", "switch argument",
        (j6 >= 0) ? log_arg[j6] : 0, SW_ARG);
    chk(j6 >= 0 && log_idx[j6+1] == 13 && (log_t[j6+1] - rsp_t[j6]) >= TPM, "R7",
        "settle gap before status poll", (j6 >= 0) ? (log_t[j6+1] - rsp_t[j6]) : -1, TPM);
    chk(log_idx[0] == 0 && log_arg[0] == 0, "R2", "first command", log_idx[0], 0);

    // R2 idle-state mismatch on CMD0 leads to stop and retry
    run("R2", 0, 0, 0, 1, 4, 0, 0, 0, 1);
    // R8 status reports switch error bit 7 once
    run("R8", 0, 2, 13, 1, 3, 0, 2, 0, 1);
    // R8 crc fault on select
    run("R8", 1, 0, 7, 2, 2, 0, 0, 0, 1);
    // R9 persistent timeout on CSD read
    run("R9", 0, 0, 9, MAX_RETRY + 1, 1, 0, 0, 0, 1);
    // R3 device never ready
    run("R3", MAX_POLLS, 0, -1, 0, 0, 0, 0, 0, 1);
    // R5 identification mismatch
    run("R5", 0, 0, -1, 0, 0, 1, 1, 0, 1);
    chk(log_idx[log_n-1] == 2, "R5", "last command after mismatch", log_idx[log_n-1], 2);
    // R11 rerun after failure completes
    run("R11", 0, 0, -1, 0, 0, 0, 0, 0, 1);

    // constrained random, fixed seed
    void'($urandom(32'd12345));
    for (int r = 0; r < 8; r++)
      run("R8", int'($urandom % 5), int'($urandom % 4), ecmds[$urandom % 8],
          int'($urandom % 3), int'($urandom % 4), 0, int'($urandom % 4), 1'b1, 1);

    chk(hs_viol == 0, "R10", "handshake violations", hs_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule